// File: doc/BRIEF.md
# External Interrupt Edge Port

This block sits between a few external interrupt request pins and a processor. Each request pin is active low. It passes through a two-stage synchroniser and is then sensed in one of two ways. In level mode a pin sets its pending flag on every cycle it is held low. In falling-edge mode a pin sets its flag once, on the high-to-low transition. Each flag is stored in a pending register and stays set until software clears it. A new event on one pin is never lost because another flag is pending or being cleared.

Software reaches three registers over a single-cycle bus: the sense-mode register, the enable register and the pending register. Bits of the pending register are cleared by writing ones. Software can therefore read the register, service the flags it saw, and write the same value back. Only those flags are cleared, and anything raised in the meantime stays pending. The enable register gates each flag into a combined request line. An index output names the highest-numbered pin whose flag is pending and enabled, so a higher pin always wins.

Top module: `xirq_edge_port`

## Requirements
- R1: After reset the mode, enable and pending registers all read 0, `irq` is 0 and `irq_id` is 0.
- R2: An event on pin n sets only bit n of the pending register, which is at address 2.
- R3: With mode bit n = 1 (falling edge), a high-to-low change on pin n becomes visible in the pending register after the third rising clock edge. A pin that stays low does not set the flag again once it has been cleared.
- R4: With mode bit n = 0 (level), the flag for pin n is set on every cycle the synchronised pin is low. A clear therefore sticks only after the pin has been high for three edges.
- R5: A write to address 2 clears each pending bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R6: If a set event and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: Writing back a value read earlier from address 2 clears exactly the bits in that value. A flag raised after the read stays pending.
- R8: Enable register bit n (address 1) gates flag n into `irq` and `irq_id`. The pending register latches events regardless of enable.
- R9: `irq` is 1 exactly when some pending bit is also enabled. `irq_id` is the highest such bit index, or 0 when there is none.
- R10: Address 0 holds the mode register and address 1 the enable register. Both read back what was written. Address 3 reads 0, and writes to it change no register.
- R11: An event on any pin is latched while other flags are pending, are being cleared, or are being written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_n | input | NUM_PINS | Asynchronous interrupt request pins, active low |
| bus_addr | input | 2 | Register address: 0 mode, 1 enable, 2 pending |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Read data for the addressed register, combinational |
| irq | output | 1 | Any enabled flag pending |
| irq_id | output | $clog2(NUM_PINS) | Index of the highest enabled pending flag |

## Verification
The assertions assume that reset is held for at least one rising edge and that the pins sit high while it is held. Otherwise the edge one-shot and set-over-clear checks could see a stale low level left over from reset. They also assume that the bus strobe is sampled only at rising edges. The bench changes pins and bus signals only on falling edges and keeps every pin high through reset. Random pin toggles and random write-backs are checked against a cycle model, and directed cases place a clear in exactly the cycle of a set.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_MODE    = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_PENDING = 2'd2,
        SEL_UNUSED  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stage[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            s_d.stage[k] = s_q.stage[k-1];
        end
    end

    // idle level of the request pins is high
    always_ff @(posedge clk) begin
        if (rst) s_q <= '1;
        else     s_q <= s_d;
    end

    assign dout = s_q.stage[STAGES-1];

endmodule

// File: rtl/xirq_detect.sv
module xirq_detect #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] sync_pin,
    input  logic [WIDTH-1:0] edge_mode,
    output logic [WIDTH-1:0] set_vec
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.prev = sync_pin;
    end

    always_ff @(posedge clk) begin
        if (rst) det_q <= '1;
        else     det_q <= det_d;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // edge mode: high then low; level mode: low now
        assign set_vec[i] = edge_mode[i] ? (det_q.prev[i] & ~sync_pin[i]) : ~sync_pin[i];

        AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
            (edge_mode[i] && $past(edge_mode[i]) && $past(set_vec[i])) |-> !set_vec[i]); // R3
    end

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic                  wr,
    input  logic [WIDTH-1:0]      wdata,
    input  logic [WIDTH-1:0]      set_vec,
    output logic [WIDTH-1:0]      rdata,
    output logic [WIDTH-1:0]      edge_mode,
    output logic [WIDTH-1:0]      enable,
    output logic [WIDTH-1:0]      pending
);

    typedef struct packed {
        logic [WIDTH-1:0] mode;
        logic [WIDTH-1:0] en;
        logic [WIDTH-1:0] flags;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;
    logic [WIDTH-1:0] clr_mask;

    assign sel      = reg_sel_e'(addr);
    assign clr_mask = (wr && sel == SEL_PENDING) ? wdata : '0;

    always_comb begin
        r_d = r_q;
        if (wr && sel == SEL_MODE)   r_d.mode = wdata;
        if (wr && sel == SEL_ENABLE) r_d.en   = wdata;
        // a set in the same cycle as a clear wins
        r_d.flags = (r_q.flags & ~clr_mask) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_comb begin
        unique case (sel)
            SEL_MODE:    rdata = r_q.mode;
            SEL_ENABLE:  rdata = r_q.en;
            SEL_PENDING: rdata = r_q.flags;
            default:     rdata = '0;
        endcase
    end

    assign edge_mode = r_q.mode;
    assign enable    = r_q.en;
    assign pending   = r_q.flags;

    AST_CLEAR_NEEDS_W1C: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (($past(r_q.flags) & ~r_q.flags & ~$past(clr_mask)) == '0)); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (($past(set_vec) & ~r_q.flags) == '0)); // R6
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wr && sel == SEL_MODE) |-> $stable(r_q.mode)); // R10
    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wr && sel == SEL_ENABLE) |-> $stable(r_q.en)); // R10

endmodule

// File: rtl/xirq_prio.sv
module xirq_prio #(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pending,
    input  logic [WIDTH-1:0] enable,
    output logic             irq,
    output logic [IDX_W-1:0] irq_id
);

    logic [WIDTH-1:0] masked;

    assign masked = pending & enable;
    assign irq    = |masked;

    // scan upward so the highest index is kept
    always_comb begin
        irq_id = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (masked[i]) irq_id = IDX_W'(i);
        end
    end

    AST_ID_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (irq_id == '0)); // R9
    AST_ID_IS_TOP: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((pending & enable) >> irq_id) == WIDTH'(1)); // R9

endmodule

// File: rtl/xirq_edge_port.sv
module xirq_edge_port
    import xirq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PINS-1:0]         pin_n,
    input  logic [REG_ADDR_W-1:0]       bus_addr,
    input  logic                        bus_wr,
    input  logic [NUM_PINS-1:0]         bus_wdata,
    output logic [NUM_PINS-1:0]         bus_rdata,
    output logic                        irq,
    output logic [$clog2(NUM_PINS)-1:0] irq_id
);

    localparam int unsigned SYNC_STAGES = 2;

    logic [NUM_PINS-1:0] sync_pin;
    logic [NUM_PINS-1:0] edge_mode;
    logic [NUM_PINS-1:0] set_vec;
    logic [NUM_PINS-1:0] enable;
    logic [NUM_PINS-1:0] pending;

    xirq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pin_n),
        .dout(sync_pin)
    );

    xirq_detect #(.WIDTH(NUM_PINS)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .sync_pin (sync_pin),
        .edge_mode(edge_mode),
        .set_vec  (set_vec)
    );

    xirq_regs #(.WIDTH(NUM_PINS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .set_vec  (set_vec),
        .rdata    (bus_rdata),
        .edge_mode(edge_mode),
        .enable   (enable),
        .pending  (pending)
    );

    xirq_prio #(.WIDTH(NUM_PINS)) u_prio (
        .clk    (clk),
        .rst    (rst),
        .pending(pending),
        .enable (enable),
        .irq    (irq),
        .irq_id (irq_id)
    );

endmodule

// File: tb/xirq_edge_port_bench.sv
module xirq_edge_port_bench;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin_n = '1;
    logic [1:0]   bus_addr = 2'd0;
    logic         bus_wr = 1'b0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         irq;
    logic [2:0]   irq_id;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    xirq_edge_port #(.NUM_PINS(N)) u_xirq_edge_port (
        .clk(clk), .rst(rst), .pin_n(pin_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .irq_id(irq_id)
    );

    // cycle model built from the requirements
    logic [N-1:0] m_s1, m_s2, m_prev, m_mode, m_en, m_flags;

    always @(posedge clk) begin
        logic [N-1:0] setv, clr;
        if (rst) begin
            m_s1 = '1; m_s2 = '1; m_prev = '1;
            m_mode = '0; m_en = '0; m_flags = '0;
        end else begin
            for (int i = 0; i < N; i++)
                setv[i] = m_mode[i] ? (m_prev[i] & ~m_s2[i]) : ~m_s2[i];
            clr = (bus_wr && bus_addr == 2'd2) ? bus_wdata : '0;
            m_flags = (m_flags & ~clr) | setv;
            if (bus_wr && bus_addr == 2'd0) m_mode = bus_wdata;
            if (bus_wr && bus_addr == 2'd1) m_en = bus_wdata;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_n;
        end
    end

    function automatic logic [N-1:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_mode;
            2'd1:    return m_en;
            2'd2:    return m_flags;
            default: return '0;
        endcase
    endfunction

    function automatic logic [2:0] exp_id(input logic [N-1:0] m);
        logic [2:0] r = '0;
        for (int i = 0; i < N; i++) if (m[i]) r = 3'(i);
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [N-1:0] exp);
        logic [N-1:0] v;
        rd(a, v);
        chk(req, $sformatf("reg%0d", a), 32'(v), 32'(exp));
    endtask

    task automatic chk_irq(input string req, input logic e_irq, input logic [2:0] e_id);
        #1;
        chk(req, "irq", 32'(irq), 32'(e_irq));
        chk(req, "irq_id", 32'(irq_id), 32'(e_id));
    endtask

    task automatic pulse(input int p);
        pin_n[p] = 1'b0; tick(1); pin_n[p] = 1'b1; tick(3);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] snap, v;
        void'($urandom(32'd4711));
        @(negedge clk); tick(4); rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) chk_reg("R1", 2'(a), '0);
        chk_irq("R1", 1'b0, 3'd0);

        // R10 register map
        wr(2'd0, 8'hF0); wr(2'd1, 8'hFF);
        chk_reg("R10", 2'd0, 8'hF0);
        chk_reg("R10", 2'd1, 8'hFF);
        wr(2'd3, 8'hFF);
        chk_reg("R10", 2'd3, 8'h00);
        chk_reg("R10", 2'd0, 8'hF0);
        chk_reg("R10", 2'd2, 8'h00);

        // R3 edge latency and one-shot, R2 bit ownership
        pin_n[5] = 1'b0; tick(2);
        chk_reg("R3", 2'd2, 8'h00);
        tick(1);
        chk_reg("R2", 2'd2, 8'h20);
        wr(2'd2, 8'h20); tick(3);
        chk_reg("R3", 2'd2, 8'h00);
        pin_n[5] = 1'b1; tick(3);

        // R4 level mode
        pin_n[1] = 1'b0; tick(3);
        chk_reg("R4", 2'd2, 8'h02);
        wr(2'd2, 8'h02);
        chk_reg("R4", 2'd2, 8'h02);
        pin_n[1] = 1'b1; tick(3);
        wr(2'd2, 8'h02);
        chk_reg("R4", 2'd2, 8'h00);

        // R6 set and clear in the same cycle
        pin_n[6] = 1'b0; tick(3); pin_n[6] = 1'b1; tick(3);
        chk_reg("R2", 2'd2, 8'h40);
        pin_n[6] = 1'b0; tick(2);
        wr(2'd2, 8'h40);
        chk_reg("R6", 2'd2, 8'h40);
        wr(2'd2, 8'h40);
        chk_reg("R6", 2'd2, 8'h00);
        pin_n[6] = 1'b1; tick(3);

        // R9 priority, R5 selective clear
        pulse(2);
        chk_irq("R9", 1'b1, 3'd2);
        pulse(3);
        chk_reg("R11", 2'd2, 8'h0C);
        chk_irq("R9", 1'b1, 3'd3);
        wr(2'd2, 8'h08);
        chk_reg("R5", 2'd2, 8'h04);
        chk_irq("R9", 1'b1, 3'd2);

        // R7 write-back of a snapshot
        pulse(0);
        rd(2'd2, snap);
        chk("R7", "snapshot", 32'(snap), 32'h05);
        pulse(1);
        wr(2'd2, snap);
        chk_reg("R7", 2'd2, 8'h02);
        chk_irq("R7", 1'b1, 3'd1);

        // R8 enable gating
        wr(2'd1, 8'h00);
        pin_n[4] = 1'b0; tick(3); pin_n[4] = 1'b1; tick(3);
        chk_reg("R8", 2'd2, 8'h12);
        chk_irq("R8", 1'b0, 3'd0);
        wr(2'd1, 8'h02);
        chk_irq("R8", 1'b1, 3'd1);
        wr(2'd1, 8'h10);
        chk_irq("R8", 1'b1, 3'd4);
        wr(2'd2, 8'hFF);
        chk_irq("R9", 1'b0, 3'd0);

        // random phase against the model, R11
        snap = '0;
        for (int c = 0; c < 4000; c++) begin
            int r;
            for (int p = 0; p < N; p++) if ($urandom % 6 == 0) pin_n[p] = ~pin_n[p];
            r = $urandom % 100;
            bus_wr = 1'b0;
            bus_addr = 2'($urandom % 4);
            bus_wdata = N'($urandom);
            if (r < 15) begin bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = snap; end
            else if (r < 25) begin bus_wr = 1'b1; bus_addr = 2'd2; end
            else if (r < 28) begin bus_wr = 1'b1; bus_addr = 2'd0; end
            else if (r < 32) begin bus_wr = 1'b1; bus_addr = 2'd1; end
            #1;
            v = bus_rdata;
            if (bus_addr == 2'd2) snap = v;
            chk(bus_addr == 2'd2 ? "R11" : "R10", "rand rd", 32'(v), 32'(exp_read(bus_addr)));
            chk("R9", "rand irq", 32'(irq), 32'(|(m_flags & m_en)));
            chk("R9", "rand id", 32'(irq_id), 32'(exp_id(m_flags & m_en)));
            @(posedge clk); @(negedge clk);
        end
        bus_wr = 1'b0;
        finish_run();
    end

endmodule